// File: doc/BRIEF.md
# Latched Interrupt Flag Controller

This block gathers event pulses from the monitors of a power-management controller and latches each one into its own flag bit. There are two flag groups. The first covers rising and falling edges of one general-purpose input and of the enable pin, two thermal-alarm crossings and a dropout detector. The second covers rising and falling edges of a second general-purpose input and fault events from four regulators. Each flag has a mask bit. Software reads a flag group to learn which events happened, and that same read clears the group.

The block drives an active-low interrupt request. The request goes low when an unmasked flag changes from 0 to 1. It goes high again only once every flag in both groups is cleared, masked flags included. A live status word shows the same request level. All access goes through a simple single-cycle read/write port. Read data is combinational in the cycle that `rdEn` is high, and a clearing read takes effect at the end of that cycle.

Top module: `pmicIrqHub`

## Requirements
- R1: After reset `irqN` is 1 and both flag groups read 0. The group-A mask at address 2 reads 0x7F and the group-B mask at address 3 reads 0x3F, so every flag is masked.
- R2: A pulse on `evtA[i]` or `evtB[i]` sets flag i of that group at the next clock edge. The flag then stays set until its group is read. Group A bits: 0 input-A fall, 1 input-A rise, 2 enable fall, 3 enable rise, 4 thermal alarm 1, 5 thermal alarm 2, 6 dropout. Group B bits: 0 input-B fall, 1 input-B rise, 2 to 5 regulator faults 0 to 3.
- R3: A read of address 0 (group A) or address 1 (group B) returns the latched flags in bits [6:0] or [5:0], and clears that group at the end of the cycle. A second read returns 0.
- R4: An event that arrives in the same cycle as a clearing read of its group is not part of that read's data, but is set in the flag afterwards. Such an event counts as a new 0-to-1 change.
- R5: A mask bit of 1 stops its flag from pulling `irqN` low. The flag itself still latches and reads back.
- R6: A 0-to-1 change of an unmasked flag drives `irqN` low at the same clock edge that latches the flag.
- R7: `irqN` returns to 1 only at the edge where the flags of both groups become all zero, masked flags included.
- R8: Clearing the mask bit of a flag that is already set does not drive `irqN` low.
- R9: Mask writes keep only bits [6:0] (address 2) or [5:0] (address 3). Reserved bits read as 0. Writes to addresses 0, 1 and 4 have no effect.
- R10: A read of address 4 returns the current `irqN` level in bit 0 (1 = high) and 0 in bits [7:1].
- R11: A read of any other address returns 0 and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtA | input | 7 | Single-cycle event pulses for flag group A |
| evtB | input | 6 | Single-cycle event pulses for flag group B |
| rdEn | input | 1 | Read strobe; a read of a flag group clears it |
| wrEn | input | 1 | Write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle rdEn is high, otherwise 0 |
| irqN | output | 1 | Active-low interrupt request |

## Verification
Two functions can fall in the same cycle: the clearing read of a flag group and a new event pulse on that group. The bench provokes this by driving an event together with the read, both on a bit that is clear and on a bit that is already set. It checks that the read returns only the flags latched before that cycle, that the new event is still set in the next read, and that `irqN` stays low until that later read empties both groups.

// File: rtl/irqHubPkg.sv
package irqHubPkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_FLAG_A = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG_B = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK_A = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK_B = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 3'd4;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_FLAGA = 3'd1,
    SEL_FLAGB = 3'd2,
    SEL_MASKA = 3'd3,
    SEL_MASKB = 3'd4,
    SEL_STAT  = 3'd5
  } rdSel_e;

  typedef struct packed {
    logic   clrA;
    logic   clrB;
    logic   wrMaskA;
    logic   wrMaskB;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/irqFlagBank.sv
module irqFlagBank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] evt,
  input  logic         clr,
  input  logic         wrMask,
  input  logic [W-1:0] maskIn,
  output logic [W-1:0] flags,
  output logic [W-1:0] mask,
  output logic         raise,
  output logic         emptyNext
);

  logic [W-1:0] kept;
  logic [W-1:0] fresh;
  logic [W-1:0] flagsNext;

  always_comb begin
    kept      = clr ? '0 : flags;
    fresh     = evt & ~kept;
    flagsNext = kept | evt;
    raise     = |(fresh & ~mask);
    emptyNext = (flagsNext == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      mask  <= '1;
    end else begin
      flags <= flagsNext;
      if (wrMask) mask <= maskIn;
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && evt == '0) |=> $stable(flags)); // R2

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt))); // R4

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (clr && evt == '0) |=> (flags == '0)); // R3

  AST_MASK_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrMask |=> $stable(mask)); // R9

endmodule

// File: rtl/irqHubCtrl.sv
module irqHubCtrl
  import irqHubPkg::*;
(
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe
);

  always_comb begin
    strobe       = '0;
    strobe.rdSel = SEL_NONE;
    if (rdEn) begin
      unique case (addr)
        ADDR_FLAG_A: begin
          strobe.clrA  = 1'b1;
          strobe.rdSel = SEL_FLAGA;
        end
        ADDR_FLAG_B: begin
          strobe.clrB  = 1'b1;
          strobe.rdSel = SEL_FLAGB;
        end
        ADDR_MASK_A: strobe.rdSel = SEL_MASKA;
        ADDR_MASK_B: strobe.rdSel = SEL_MASKB;
        ADDR_STAT:   strobe.rdSel = SEL_STAT;
        default:     strobe.rdSel = SEL_NONE;
      endcase
    end
    if (wrEn) begin
      strobe.wrMaskA = (addr == ADDR_MASK_A);
      strobe.wrMaskB = (addr == ADDR_MASK_B);
    end
  end

endmodule

// File: rtl/irqHubData.sv
module irqHubData
  import irqHubPkg::*;
#(
  parameter int A_W    = 7,
  parameter int B_W    = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [A_W-1:0]    evtA,
  input  logic [B_W-1:0]    evtB,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN
);

  localparam int NBANK = 2;

  logic [A_W-1:0] flagsA, maskA;
  logic [B_W-1:0] flagsB, maskB;
  logic [NBANK-1:0] raise;
  logic [NBANK-1:0] emptyNext;
  logic irqActive;
  logic irqNext;

  irqFlagBank #(.W(A_W)) bankA (
    .clk(clk), .rstN(rstN), .evt(evtA), .clr(strobe.clrA),
    .wrMask(strobe.wrMaskA), .maskIn(wrData[A_W-1:0]),
    .flags(flagsA), .mask(maskA), .raise(raise[0]), .emptyNext(emptyNext[0])
  );

  irqFlagBank #(.W(B_W)) bankB (
    .clk(clk), .rstN(rstN), .evt(evtB), .clr(strobe.clrB),
    .wrMask(strobe.wrMaskB), .maskIn(wrData[B_W-1:0]),
    .flags(flagsB), .mask(maskB), .raise(raise[1]), .emptyNext(emptyNext[1])
  );

  // Release has priority: an empty next state cannot hold a fresh flag anyway.
  always_comb begin
    if (&emptyNext)   irqNext = 1'b0;
    else if (|raise)  irqNext = 1'b1;
    else              irqNext = irqActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqActive <= 1'b0;
    else       irqActive <= irqNext;
  end

  assign irqN = ~irqActive;

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      SEL_FLAGA: rdData[A_W-1:0] = flagsA;
      SEL_FLAGB: rdData[B_W-1:0] = flagsB;
      SEL_MASKA: rdData[A_W-1:0] = maskA;
      SEL_MASKB: rdData[B_W-1:0] = maskB;
      SEL_STAT:  rdData[0]       = irqN;
      default:   rdData          = '0;
    endcase
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (flagsA != '0 || flagsB != '0)); // R7

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(|raise)); // R6

  AST_IRQ_RISE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqN) |-> (flagsA == '0 && flagsB == '0)); // R7

endmodule

// File: rtl/pmicIrqHub.sv
module pmicIrqHub
  import irqHubPkg::*;
#(
  parameter int A_W    = 7,
  parameter int B_W    = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [A_W-1:0]    evtA,
  input  logic [B_W-1:0]    evtB,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN
);

  strobe_t strobe;

  irqHubCtrl ctrl (
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .strobe(strobe)
  );

  irqHubData #(.A_W(A_W), .B_W(B_W), .DATA_W(DATA_W)) data (
    .clk(clk), .rstN(rstN), .evtA(evtA), .evtB(evtB), .strobe(strobe),
    .wrData(wrData), .rdData(rdData), .irqN(irqN)
  );

endmodule

// File: tb/pmicIrqHub_test.sv
module pmicIrqHub_test;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [6:0] evtA;
  logic [5:0] evtB;
  logic       rdEn, wrEn;
  logic [2:0] addr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       irqN;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(PERIOD/2) clk = ~clk;

  pmicIrqHub uut (
    .clk(clk), .rstN(rstN), .evtA(evtA), .evtB(evtB), .rdEn(rdEn),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .irqN(irqN)
  );

  // Monitor: samples mid-cycle, pops the expected value pushed by the driver.
  always @(negedge clk) begin
    if (rstN && rdEn) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %02h expected none", rdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s addr %0d: actual %02h expected %02h", t, addr, rdData, e);
        end
      end
    end
  end

  task automatic cyc(input logic [6:0] a, input logic [5:0] b, input logic rd,
                     input logic wr, input logic [2:0] ad, input logic [7:0] wd);
    evtA = a; evtB = b; rdEn = rd; wrEn = wr; addr = ad; wrData = wd;
    @(posedge clk); #1;
    evtA = '0; evtB = '0; rdEn = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic rdEv(input logic [2:0] ad, input logic [6:0] a, input logic [5:0] b,
                      input logic [7:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    cyc(a, b, 1'b1, 1'b0, ad, 8'h00);
  endtask

  task automatic rd(input logic [2:0] ad, input logic [7:0] e, input string t);
    rdEv(ad, 7'h00, 6'h00, e, t);
  endtask

  task automatic wr(input logic [2:0] ad, input logic [7:0] wd);
    cyc(7'h00, 6'h00, 1'b0, 1'b1, ad, wd);
  endtask

  task automatic ev(input logic [6:0] a, input logic [5:0] b);
    cyc(a, b, 1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic chkIrq(input logic e, input string t);
    checks++;
    if (irqN !== e) begin
      errors++;
      $display("FAIL %s irqN: actual %0b expected %0b", t, irqN, e);
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; evtA = '0; evtB = '0; rdEn = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    chkIrq(1'b1, "R1");
    rd(3'd0, 8'h00, "R1 flagsA");
    rd(3'd1, 8'h00, "R1 flagsB");
    rd(3'd2, 8'h7F, "R1 maskA");
    rd(3'd3, 8'h3F, "R1 maskB");
    rd(3'd4, 8'h01, "R1 status");

    // R9 reserved mask bits dropped
    wr(3'd2, 8'h80);
    rd(3'd2, 8'h00, "R9 maskA reserved");
    wr(3'd3, 8'hC0);
    rd(3'd3, 8'h00, "R9 maskB reserved");

    // R2 / R6 / R10 / R3 single unmasked event
    ev(7'h02, 6'h00);
    chkIrq(1'b0, "R6 unmasked rise");
    rd(3'd4, 8'h00, "R10 status low");
    rd(3'd0, 8'h02, "R2 input-A rise flag");
    chkIrq(1'b1, "R7 released after clear");
    rd(3'd0, 8'h00, "R3 second read empty");

    // R7 both groups pending
    ev(7'h10, 6'h04);
    chkIrq(1'b0, "R6 two groups");
    rd(3'd0, 8'h10, "R2 thermal alarm 1");
    chkIrq(1'b0, "R7 group B still set");
    rd(3'd1, 8'h04, "R2 regulator fault 0");
    chkIrq(1'b1, "R7 all clear");

    // R5 masked flag latches without request
    wr(3'd2, 8'h40);
    ev(7'h40, 6'h00);
    chkIrq(1'b1, "R5 masked no request");
    rd(3'd0, 8'h40, "R5 masked flag latched");
    chkIrq(1'b1, "R5 after read");

    // R7 masked flag holds the request low
    ev(7'h40, 6'h00);
    ev(7'h00, 6'h01);
    chkIrq(1'b0, "R6 group B input fall");
    rd(3'd1, 8'h01, "R2 input-B fall");
    chkIrq(1'b0, "R7 masked flag pending");
    rd(3'd0, 8'h40, "R7 masked dropout");
    chkIrq(1'b1, "R7 released");

    // R8 unmasking a set flag
    ev(7'h40, 6'h00);
    wr(3'd2, 8'h00);
    ev(7'h00, 6'h00);
    chkIrq(1'b1, "R8 unmask set flag");
    rd(3'd0, 8'h40, "R8 flag still there");
    chkIrq(1'b1, "R8 after read");

    // R4 event during a clearing read
    ev(7'h08, 6'h00);
    chkIrq(1'b0, "R6 enable rise");
    rdEv(3'd0, 7'h01, 6'h00, 8'h08, "R4 read excludes new event");
    chkIrq(1'b0, "R4 new event holds request");
    rd(3'd0, 8'h01, "R4 new event kept");
    chkIrq(1'b1, "R4 released");
    ev(7'h04, 6'h00);
    rdEv(3'd0, 7'h04, 6'h00, 8'h04, "R4 same bit read");
    chkIrq(1'b0, "R4 same bit re-armed");
    rd(3'd0, 8'h04, "R4 same bit kept");
    chkIrq(1'b1, "R4 same bit released");

    // R9 writes to flag/status addresses ignored, R11 unmapped read
    ev(7'h00, 6'h20);
    wr(3'd1, 8'h00);
    rd(3'd1, 8'h20, "R9 flag write ignored");
    chkIrq(1'b1, "R7 after fault 3 read");
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h01, "R9 status write ignored");
    ev(7'h01, 6'h00);
    rd(3'd5, 8'h00, "R11 unmapped read");
    chkIrq(1'b0, "R11 nothing cleared");
    rd(3'd0, 8'h01, "R11 flag survives");
    chkIrq(1'b1, "R11 released");

    // full patterns
    wr(3'd2, 8'h7F);
    ev(7'h7F, 6'h00);
    chkIrq(1'b1, "R5 all A masked");
    rd(3'd0, 8'h7F, "R2 all A flags");
    ev(7'h00, 6'h3F);
    chkIrq(1'b0, "R6 all B");
    rd(3'd1, 8'h3F, "R2 all B flags");
    chkIrq(1'b1, "R7 final release");

    @(posedge clk); #1;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule